// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block moderates completion interrupts for one transfer channel. Rather than interrupting on every finished packet, it counts completions down from a programmable batch threshold. When the count reaches zero it emits a one-cycle set pulse for the completion interrupt flag and starts a new batch. A second mechanism covers a batch that never fills. Each completion can restart a one-shot delay timer. If the timer runs out before more traffic arrives, the block pulses the delay interrupt flag and discards the partial batch by reloading the counter.

The timer advances only on cycles where the tick enable is high, so an external prescaler sets the timeout resolution. A delay value of zero disables the timer. The live counter and timer values are exported for a status register. Flag storage, masking and register access belong to the surrounding logic.

The delay timer is a two-state machine. In IDLE the timer is stopped and holds zero. In RUN it counts down on ticks. The transitions are:
- START: IDLE to RUN, on a completion with a nonzero delay.
- RESTART: RUN to RUN, on a completion with a nonzero delay.
- EXPIRE: RUN to IDLE, on a tick while the count is 1 and no restart occurs in the same cycle.
- HOLD: any other cycle leaves the state unchanged.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset, `cnt_o` is 0, `tmr_o` is 0, the timer is in IDLE, and both set pulses are low.
- R2: A cycle with `reload_i` high and `cmpl_i` low leaves `cnt_o` equal to that cycle's `thresh_i` after the next clock edge.
- R3: Each `cmpl_i` cycle decrements the counter. A completion that finds the count at 1 instead produces `ioc_set_o` high for exactly the following cycle, and the counter reloads from `thresh_i`.
- R4: A `cmpl_i` cycle with nonzero `delay_i` loads `tmr_o` with `delay_i` and puts the timer in RUN. This happens whether or not the timer was already running.
- R5: A `cmpl_i` cycle with `delay_i` equal to 0 does not touch the timer: it neither starts, restarts nor stops it.
- R6: While running, the timer decreases by one only on cycles where `tick_i` is high. On all other cycles it holds its value. In RUN the count is never 0.
- R7: A tick with the running count at 1 takes the timer to 0 and IDLE. It raises `dly_set_o` for the following cycle and reloads the counter from `thresh_i`.
- R8: If an expiry and a completion with nonzero delay fall in the same cycle, `dly_set_o` still pulses and the timer restarts at `delay_i`. The completion is counted against the freshly reloaded threshold.
- R9: A threshold of 0 acts as 256. The counter wraps from 0 to 255, and the 256th completion after the reload produces `ioc_set_o`.
- R10: If `reload_i` and `cmpl_i` are high together, the completion is counted against `thresh_i`. With `thresh_i` equal to 1, this raises `ioc_set_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_i | input | 1 | One packet completed this cycle |
| reload_i | input | 1 | Reload the counter from the threshold |
| thresh_i | input | 8 | Batch threshold (0 means 256) |
| delay_i | input | 8 | Delay timer start value (0 disables the timer) |
| tick_i | input | 1 | Timer decrement enable |
| ioc_set_o | output | 1 | Set pulse for the completion interrupt flag |
| dly_set_o | output | 1 | Set pulse for the delay interrupt flag |
| cnt_o | output | 8 | Live completion counter |
| tmr_o | output | 8 | Live delay timer count |

## Verification
The hardest case to reach is a timer expiry in the same cycle as a completion. The stimulus has to know the exact cycle in which the timer holds 1, then raise a tick and a completion together. The bench gets there by loading a delay of 2 and issuing one lone tick, which leaves the count at 1. It then drives tick and completion in the same cycle. The 256-completion batch for threshold 0 is reached by a long completion run with the timer disabled. A reference model compares all four outputs on every clock throughout these runs and through a randomized traffic phase.

// File: rtl/icc_pkg.sv
package icc_pkg;
    typedef enum logic [0:0] {
        T_IDLE = 1'b0,
        T_RUN  = 1'b1
    } tmr_state_e;
endpackage

// File: rtl/icc_delay_timer.sv
module icc_delay_timer
    import icc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmpl_i,
    input  logic [W-1:0] delay_i,
    input  logic         tick_i,
    output logic         expire_o,
    output logic         dly_set_o,
    output logic [W-1:0] tmr_o
);
    localparam logic [W-1:0] ONE = W'(1);

    tmr_state_e  state_q, state_d;
    logic [W-1:0] tmr_q;
    logic        load;
    logic        expire;

    assign load   = cmpl_i && (delay_i != '0);
    assign expire = (state_q == T_RUN) && tick_i && (tmr_q == ONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= T_IDLE;
        else        state_q <= state_d;
    end

    // next-state: START, RESTART, EXPIRE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            T_IDLE: if (load) state_d = T_RUN;
            T_RUN: begin
                if (load)        state_d = T_RUN;
                else if (expire) state_d = T_IDLE;
            end
            default: state_d = T_IDLE;
        endcase
    end

    // outputs: count and expiry pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q     <= '0;
            dly_set_o <= 1'b0;
        end else begin
            dly_set_o <= expire;
            if (load)                            tmr_q <= delay_i;
            else if (expire)                     tmr_q <= '0;
            else if (state_q == T_RUN && tick_i) tmr_q <= tmr_q - ONE;
        end
    end

    assign tmr_o    = tmr_q;
    assign expire_o = expire;

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && delay_i != '0) |=> (tmr_q == $past(delay_i) && state_q == T_RUN)); // R4
    AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !(cmpl_i && delay_i != '0)) |=> $stable(tmr_q)); // R6
    AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_RUN) |-> (tmr_q != '0)); // R6
    AST_EXPIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_RUN && tick_i && tmr_q == ONE && !cmpl_i) |=> (dly_set_o && tmr_q == '0 && state_q == T_IDLE)); // R7
endmodule

// File: rtl/icc_batch_counter.sv
module icc_batch_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmpl_i,
    input  logic         reload_i,
    input  logic         expire_i,
    input  logic [W-1:0] thresh_i,
    output logic         ioc_set_o,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] base;
    logic         hit;

    // a reload or an expiry discards the partial batch before counting
    assign base = (reload_i || expire_i) ? thresh_i : cnt_q;
    assign hit  = cmpl_i && (base == ONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            ioc_set_o <= 1'b0;
        end else begin
            ioc_set_o <= hit;
            if (hit)         cnt_q <= thresh_i;
            else if (cmpl_i) cnt_q <= base - ONE;   // 0 wraps to max
            else             cnt_q <= base;
        end
    end

    assign cnt_o = cnt_q;

    AST_IOC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ioc_set_o |-> (cnt_q == $past(thresh_i))); // R3
    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_i && !cmpl_i) |=> (cnt_q == $past(thresh_i))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmpl_i && !reload_i && !expire_i) |=> ($stable(cnt_q) && !ioc_set_o)); // R3
endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer #(
    parameter int CNT_W = 8,
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmpl_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] thresh_i,
    input  logic [TMR_W-1:0] delay_i,
    input  logic             tick_i,
    output logic             ioc_set_o,
    output logic             dly_set_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [TMR_W-1:0] tmr_o
);
    logic expire;

    icc_delay_timer #(.W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmpl_i    (cmpl_i),
        .delay_i   (delay_i),
        .tick_i    (tick_i),
        .expire_o  (expire),
        .dly_set_o (dly_set_o),
        .tmr_o     (tmr_o)
    );

    icc_batch_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmpl_i    (cmpl_i),
        .reload_i  (reload_i),
        .expire_i  (expire),
        .thresh_i  (thresh_i),
        .ioc_set_o (ioc_set_o),
        .cnt_o     (cnt_o)
    );

    AST_DLY_RELOADS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cmpl_i) |=> (dly_set_o && cnt_o == $past(thresh_i))); // R7
    AST_NO_CMPL_TMR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_i && delay_i == '0 && !tick_i) |=> $stable(tmr_o)); // R5
endmodule

// File: tb/tb_cmpl_irq_coalescer.sv
module tb_cmpl_irq_coalescer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmpl_i = 1'b0, reload_i = 1'b0, tick_i = 1'b0;
    logic [7:0] thresh_i = 8'd0, delay_i = 8'd0;
    logic       ioc_set_o, dly_set_o;
    logic [7:0] cnt_o, tmr_o;

    int checks = 0, fails = 0;
    string phase = "R1";
    bit finished = 0;

    // reference model state
    int m_cnt = 0, m_tmr = 0, m_run = 0, m_ioc = 0, m_dly = 0;

    always #10 clk = ~clk;  // 50 MHz

    cmpl_irq_coalescer dut (
        .clk(clk), .rst_n(rst_n), .cmpl_i(cmpl_i), .reload_i(reload_i),
        .thresh_i(thresh_i), .delay_i(delay_i), .tick_i(tick_i),
        .ioc_set_o(ioc_set_o), .dly_set_o(dly_set_o), .cnt_o(cnt_o), .tmr_o(tmr_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_tmr = 0; m_run = 0; m_ioc = 0; m_dly = 0;
        end else begin
            int ex, base, th, dl;
            th = int'(thresh_i); dl = int'(delay_i);
            ex = (m_run == 1 && tick_i && m_tmr == 1) ? 1 : 0;
            base = (reload_i || ex == 1) ? th : m_cnt;
            m_ioc = 0;
            if (cmpl_i) begin
                if (base == 1) begin m_ioc = 1; m_cnt = th; end
                else m_cnt = (base + 255) % 256;
            end else m_cnt = base;
            if (cmpl_i && dl != 0) begin m_tmr = dl; m_run = 1; end
            else if (ex == 1) begin m_tmr = 0; m_run = 0; end
            else if (m_run == 1 && tick_i) m_tmr = m_tmr - 1;
            m_dly = ex;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk({phase, " cnt_o"}, int'(cnt_o), m_cnt);
            chk({phase, " tmr_o"}, int'(tmr_o), m_tmr);
            chk({phase, " ioc_set_o"}, int'(ioc_set_o), m_ioc);
            chk({phase, " dly_set_o"}, int'(dly_set_o), m_dly);
        end
    end

    task automatic cyc(input bit c, input bit r, input bit t);
        cmpl_i = c; reload_i = r; tick_i = t;
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1 cnt", int'(cnt_o), 0);
        chk("R1 tmr", int'(tmr_o), 0);
        chk("R1 pulses", int'(ioc_set_o) + int'(dly_set_o), 0);

        phase = "R2"; thresh_i = 8'd3; delay_i = 8'd0;
        cyc(0, 1, 0); cyc(0, 0, 0);
        chk("R2 directed reload", int'(cnt_o), 3);

        phase = "R3";
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
        chk("R3 directed ioc", int'(ioc_set_o), 1);
        cyc(0, 0, 0);

        phase = "R4"; delay_i = 8'd5;
        cyc(1, 0, 0);
        chk("R4 directed load", int'(tmr_o), 5);
        phase = "R6";
        cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 1);
        chk("R6 directed ticks", int'(tmr_o), 3);
        phase = "R4"; cyc(1, 0, 0);   // restart while running

        phase = "R5"; delay_i = 8'd0;
        cyc(1, 0, 1); cyc(1, 0, 0);
        chk("R5 directed untouched", int'(tmr_o), 4);

        phase = "R7"; thresh_i = 8'd4;
        repeat (3) cyc(0, 0, 1);
        cyc(0, 0, 1);
        chk("R7 directed dly", int'(dly_set_o), 1);
        chk("R7 directed cnt", int'(cnt_o), 4);

        phase = "R8"; delay_i = 8'd2;
        cyc(1, 0, 0); cyc(0, 0, 1);
        delay_i = 8'd6;
        cyc(1, 0, 1);
        chk("R8 directed dly", int'(dly_set_o), 1);
        chk("R8 directed tmr", int'(tmr_o), 6);
        chk("R8 directed cnt", int'(cnt_o), 3);

        phase = "R10"; thresh_i = 8'd1; delay_i = 8'd0;
        cyc(1, 1, 0);
        chk("R10 directed ioc", int'(ioc_set_o), 1);

        phase = "R9"; thresh_i = 8'd0;
        cyc(0, 1, 0);
        for (int i = 0; i < 255; i++) cyc(1, 0, 0);
        chk("R9 no early ioc", int'(ioc_set_o), 0);
        cyc(1, 0, 0);
        chk("R9 ioc at 256", int'(ioc_set_o), 1);

        phase = "R3 random";
        for (int i = 0; i < 3000; i++) begin
            thresh_i = ($urandom % 4 == 0) ? 8'($urandom % 3) : 8'($urandom % 6);
            delay_i  = 8'($urandom % 5);
            cyc(($urandom % 3) == 0, ($urandom % 29) == 0, ($urandom % 2) == 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule